// File: doc/BRIEF.md
# Strobe Watchdog Timer with Selectable Timeout

This block supervises a processor through a single strobe line. The processor is expected to drive a falling edge on the strobe regularly. If no such edge arrives within the selected timeout, the block raises a single-cycle timeout request. A reset generator elsewhere in the chip turns that request into a system reset lasting at least 250 ms. The timeout is measured in ticks of a slow timebase enable, for example one tick per millisecond. A 2-bit select chooses one of three periods.

The strobe is asynchronous to the block clock. It passes through a two-stage synchronizer, and only a high-to-low transition of the synchronized level counts as a strobe event. The timer is held clear for as long as the reset outputs of the system are active. Counting starts from zero once they are released. After every strobe event and after every timeout, the timer starts a full period again.

Top module: `strobe_watchdog`

## Requirements
- R1: While `rst` is high, `timeout` is low and the elapsed count is cleared. After `rst` falls, a full period must elapse before `timeout` can assert.
- R2: `period_sel` = 2'b00 gives 150 ticks, 2'b01 gives 600 ticks and 2'b10 gives 1200 ticks.
- R3: `period_sel` = 2'b11 gives the same period as 2'b10, which is 1200 ticks.
- R4: The elapsed count advances only in cycles where `tick_en` is high, so a cycle without a tick never raises `timeout`.
- R5: While `rst_active` is high, the count is held at zero and `timeout` stays low. After `rst_active` falls, the first `timeout` appears at the clock edge that samples the selected number of ticks.
- R6: A falling edge on `strobe_in` restarts the period. With a tick on every cycle, if the edge is driven just after clock edge a, the count is zero after edge a+3, and the next `timeout` follows after exactly one full period.
- R7: A rising edge on `strobe_in`, or a level held steady, does not restart the period.
- R8: `timeout` is high for exactly one cycle. The count then restarts, and the next `timeout` comes one full period later if no strobe arrives.
- R9: If a strobe event falls in the same cycle as the final tick of a period, the strobe event wins: no `timeout` is raised, and the period restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timebase enable, one pulse per tick |
| rst_active | input | 1 | High while the system reset outputs are active; holds the timer clear |
| strobe_in | input | 1 | Asynchronous strobe from the processor; falling edges are recognized |
| period_sel | input | 2 | Timeout select: 00 short, 01 medium, 10 or 11 long |
| timeout | output | 1 | One-cycle timeout request |

## Verification
The bench measures the exact number of clock edges from releasing `rst_active`, or from a strobe edge, to the timeout pulse, for every select code. A design that is off by one in its terminal compare, or that drops a stage from the synchronizer, gives a count that misses by one or more edges. A strobe edge is timed to land on the final tick. A design that lets the expiry win in that cycle pulses a full period early. Further tests cover a rising edge part way through a period, a tick enable held low, and `rst_active` asserted in mid-count. These expose a timer that reacts to either edge, that counts raw cycles, or that resumes counting where it stopped instead of starting again.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        SEL_SHORT  = 2'b00,
        SEL_MEDIUM = 2'b01,
        SEL_LONG   = 2'b10,
        SEL_SPARE  = 2'b11
    } period_sel_e;

    typedef struct packed {
        logic hold;     // timer forced clear
        logic restart;  // strobe event seen this cycle
        logic tick;     // timebase enable
    } wdt_ctl_t;

    function automatic int unsigned pick_period(
        input period_sel_e  sel,
        input int unsigned  short_ticks,
        input int unsigned  medium_ticks,
        input int unsigned  long_ticks
    );
        int unsigned result;
        case (sel)
            SEL_SHORT:  result = short_ticks;
            SEL_MEDIUM: result = medium_ticks;
            default:    result = long_ticks;
        endcase
        return result;
    endfunction

endpackage

// File: rtl/wdt_strobe_sync.sv
module wdt_strobe_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_async,
    output logic fall_evt
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   last_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= strobe_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain_q[SYNC_STAGES-1];
    end

    assign fall_evt = last_q & ~chain_q[SYNC_STAGES-1];
endmodule

// File: rtl/wdt_period_decode.sv
module wdt_period_decode
    import wdt_pkg::*;
#(
    parameter int unsigned SHORT_TICKS  = 150,
    parameter int unsigned MEDIUM_TICKS = 600,
    parameter int unsigned LONG_TICKS   = 1200,
    parameter int          CNT_W        = 11
) (
    input  logic [1:0]       sel_code,
    output logic [CNT_W-1:0] last_count
);
    int unsigned ticks;

    always_comb begin
        ticks      = pick_period(period_sel_e'(sel_code),
                                 SHORT_TICKS, MEDIUM_TICKS, LONG_TICKS);
        last_count = CNT_W'(ticks - 1);
    end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  wdt_ctl_t         ctl,
    input  logic [CNT_W-1:0] last_count,
    output logic [CNT_W-1:0] elapsed,
    output logic             expire
);
    logic [CNT_W-1:0] elapsed_q;
    logic             expire_q;
    logic             at_end;

    assign at_end = (elapsed_q >= last_count);

    always_ff @(posedge clk) begin
        if (rst || ctl.hold) begin
            elapsed_q <= '0;
            expire_q  <= 1'b0;
        end else begin
            expire_q <= 1'b0;
            if (ctl.restart) begin
                elapsed_q <= '0;
            end else if (ctl.tick) begin
                if (at_end) begin
                    elapsed_q <= '0;
                    expire_q  <= 1'b1;
                end else begin
                    elapsed_q <= elapsed_q + 1'b1;
                end
            end
        end
    end

    assign elapsed = elapsed_q;
    assign expire  = expire_q;
endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog
    import wdt_pkg::*;
#(
    parameter int unsigned SHORT_TICKS  = 150,
    parameter int unsigned MEDIUM_TICKS = 600,
    parameter int unsigned LONG_TICKS   = 1200,
    parameter int          SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       rst_active,
    input  logic       strobe_in,
    input  logic [1:0] period_sel,
    output logic       timeout
);
    localparam int unsigned MAX_TICKS =
        (LONG_TICKS > MEDIUM_TICKS)
            ? ((LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS)
            : ((MEDIUM_TICKS > SHORT_TICKS) ? MEDIUM_TICKS : SHORT_TICKS);
    localparam int CNT_W = $clog2(MAX_TICKS + 1);

    logic             strobe_evt;
    logic [CNT_W-1:0] last_count;
    logic [CNT_W-1:0] elapsed;
    wdt_ctl_t         ctl;

    wdt_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk          (clk),
        .rst          (rst),
        .strobe_async (strobe_in),
        .fall_evt     (strobe_evt)
    );

    wdt_period_decode #(
        .SHORT_TICKS  (SHORT_TICKS),
        .MEDIUM_TICKS (MEDIUM_TICKS),
        .LONG_TICKS   (LONG_TICKS),
        .CNT_W        (CNT_W)
    ) u_decode (
        .sel_code   (period_sel),
        .last_count (last_count)
    );

    always_comb begin
        ctl.hold    = rst_active;
        ctl.restart = strobe_evt;
        ctl.tick    = tick_en;
    end

    wdt_counter #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .last_count (last_count),
        .elapsed    (elapsed),
        .expire     (timeout)
    );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int CNT_W = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_en,
    input logic             rst_active,
    input logic             strobe_evt,
    input logic [CNT_W-1:0] elapsed,
    input logic             timeout
);
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        timeout |=> !timeout);

    p_hold_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        rst_active |=> (!timeout && elapsed == '0));

    p_tick_gate_r4: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> !timeout);

    p_strobe_wins_r9: assert property (@(posedge clk) disable iff (rst)
        strobe_evt |=> !timeout);

    p_restart_clear_r6: assert property (@(posedge clk) disable iff (rst)
        strobe_evt |=> (elapsed == '0));

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!timeout && elapsed == '0));
endmodule

bind strobe_watchdog wdt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick_en    (tick_en),
    .rst_active (rst_active),
    .strobe_evt (strobe_evt),
    .elapsed    (elapsed),
    .timeout    (timeout)
);

// File: tb/strobe_watchdog_bench.sv
module strobe_watchdog_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b1;
    logic       rst_active = 1'b1;
    logic       strobe_in = 1'b1;
    logic [1:0] period_sel = 2'b00;
    logic       timeout;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    strobe_watchdog u_strobe_watchdog (
        .clk        (clk),
        .rst        (rst),
        .tick_en    (tick_en),
        .rst_active (rst_active),
        .strobe_in  (strobe_in),
        .period_sel (period_sel),
        .timeout    (timeout)
    );

    // {select code, expected ticks}
    localparam int VEC [4][2] = '{
        '{0, 150}, '{1, 600}, '{2, 1200}, '{3, 1200}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Caller stands at a negedge; counts clock edges until timeout is seen.
    task automatic wait_pulse(input int limit, output int n);
        n = 0;
        while (n < limit) begin
            @(negedge clk);
            n++;
            if (timeout) break;
        end
    endtask

    task automatic rearm;
        @(negedge clk);
        rst_active = 1'b1;
        repeat (4) @(negedge clk);
        rst_active = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        bool_seen_t: begin end
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(timeout == 1'b0, "R1 timeout low in reset", timeout, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(timeout == 1'b0, "R1 quiet while rst_active", timeout, 0);

        // R2/R3/R8: vector table per select code
        for (int i = 0; i < 4; i++) begin
            period_sel = VEC[i][0][1:0];
            rearm();
            wait_pulse(5000, n);
            chk(n == VEC[i][1], i == 3 ? "R3 code 11 period" : "R2 period", n, VEC[i][1]);
            @(negedge clk);
            chk(timeout == 1'b0, "R8 pulse width one cycle", timeout, 0);
            wait_pulse(5000, n);
            chk(n == VEC[i][1] - 1, "R8 next pulse one period later", n + 1, VEC[i][1]);
        end

        period_sel = 2'b00;

        // R6: falling strobe restarts
        strobe_in = 1'b1;
        rearm();
        n = 0;
        while (n < 100) begin @(negedge clk); n++; end
        chk(timeout == 1'b0, "R6 no early pulse", timeout, 0);
        strobe_in = 1'b0;
        begin
            int m;
            wait_pulse(5000, m);
            chk(100 + m == 253, "R6 restart latency", 100 + m, 253);
        end

        // R7: rising edge ignored
        rearm();
        n = 0;
        while (n < 50) begin @(negedge clk); n++; end
        strobe_in = 1'b1;
        begin
            int m;
            wait_pulse(5000, m);
            chk(50 + m == 150, "R7 rising edge ignored", 50 + m, 150);
        end

        // R9: strobe event coincides with final tick
        rearm();
        n = 0;
        while (n < 147) begin @(negedge clk); n++; end
        strobe_in = 1'b0;
        begin
            int m;
            wait_pulse(5000, m);
            chk(147 + m == 300, "R9 strobe beats expiry", 147 + m, 300);
        end
        strobe_in = 1'b1;

        // R4: no tick, no progress
        @(negedge clk);
        rst_active = 1'b1;
        tick_en = 1'b0;
        repeat (4) @(negedge clk);
        rst_active = 1'b0;
        begin
            int seen = 0;
            for (int k = 0; k < 400; k++) begin
                @(negedge clk);
                if (timeout) seen++;
            end
            chk(seen == 0, "R4 no pulse without ticks", seen, 0);
        end
        tick_en = 1'b1;
        wait_pulse(5000, n);
        chk(n == 150, "R4 period counted in ticks", n, 150);

        // R5: rst_active mid-count restarts full period
        rearm();
        n = 0;
        while (n < 100) begin @(negedge clk); n++; end
        rst_active = 1'b1;
        begin
            int seen = 0;
            for (int k = 0; k < 300; k++) begin
                @(negedge clk);
                if (timeout) seen++;
            end
            chk(seen == 0, "R5 held quiet while active", seen, 0);
        end
        rst_active = 1'b0;
        wait_pulse(5000, n);
        chk(n == 150, "R5 full period after release", n, 150);

        // R1: synchronous reset mid-count clears the count
        rearm();
        n = 0;
        while (n < 120) begin @(negedge clk); n++; end
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(timeout == 1'b0, "R1 timeout low in reset", timeout, 0);
        rst = 1'b0;
        wait_pulse(5000, n);
        chk(n == 150, "R1 full period after reset", n, 150);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule